// File: doc/BRIEF.md
# Priority-Muxed GPIO Port Controller

An eight-pin I/O port whose pins can each be claimed by on-chip peripheral signals. A small register bus gives access to an output value register and a direction register. When no peripheral claims a pin, the pin is plain GPIO. Each pin has a fixed priority chain of alternate functions. The highest-priority function whose enable input is high owns the pad. It sets the pad's output value and output enable, and the direction register bit for that pin then has no effect on the pad.

Whenever a two-wire serial bus function owns a pin, the pin is open drain. It can only pull the line low, and it releases the line otherwise. Pad inputs pass through a two-flop synchronizer. The synchronized levels feed two places: the register readback, and the receive inputs of any peripheral that currently owns the matching pin. A receive input whose function does not own its pin is held at the idle level 1.

Top module: `gpio_prio_port`

## Requirements
- R1: The value register (address 0) is 8 bits wide and resets to 0. A write strobe may change it on any cycle, and the new value drives every GPIO pin from the next cycle on.
- R2: A read strobe returns data on rdata_o one cycle later, and rdata_o holds that value until the next read. At address 0, each bit returns the stored value if its direction bit is 1 and the synchronized pad level if it is 0. Address 1 returns the direction register.
- R3: On pins 7 and 6 the owner is chosen in this order, highest priority first. First comes CAN A: pin 7 transmits and pin 6 receives. Next comes two-wire bus A: pin 7 is the clock and pin 6 is the data. Then comes CAN B, with the same pin roles as CAN A. GPIO is last. A receive pin's output enable is 0.
- R4: On pins 5 and 4 the owner is chosen in this order. First comes two-wire bus B: pin 5 is the clock and pin 4 is the data. Next comes a chip select: cs bit 2 on pin 5 and cs bit 0 on pin 4. GPIO is last. A chip-select output always has its output enable at 1.
- R5: A pin owned by a two-wire function drives pad_o = 0, and its pad_oe_o equals that function's pull-low request.
- R6: Pin 3 is always GPIO.
- R7: Pin 2 is owned by cs bit 1 when that bit is enabled. On pins 1 and 0, the UART outranks GPIO: pin 1 transmits and pin 0 receives. Pin 0 additionally has cs bit 3, with priority below the UART and above GPIO.
- R8: An unclaimed pin drives pad_o from the value register and pad_oe_o from the direction register. On a claimed pin, the direction bit has no effect on pad_oe_o.
- R9: A pad input change reaches the receive outputs and the readback after exactly two clock edges.
- R10: Each receive output carries the synchronized pad level while its function owns the pin, and 1 otherwise.
- R11: After reset, the direction register is 0, every pad_oe_o is 0 while no peripheral is enabled, rdata_o is 0, and every receive output is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe |
| addr_i | input | 1 | 0 selects the value register, 1 selects the direction register |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data |
| can_a_en_i | input | 1 | CAN A enable |
| can_a_tx_i | input | 1 | CAN A transmit |
| can_a_rx_o | output | 1 | CAN A receive |
| twi_a_en_i | input | 1 | Two-wire bus A enable |
| twi_a_scl_low_i | input | 1 | Bus A clock pull-low request |
| twi_a_sda_low_i | input | 1 | Bus A data pull-low request |
| twi_a_scl_o | output | 1 | Bus A clock line level |
| twi_a_sda_o | output | 1 | Bus A data line level |
| can_b_en_i | input | 1 | CAN B enable |
| can_b_tx_i | input | 1 | CAN B transmit |
| can_b_rx_o | output | 1 | CAN B receive |
| twi_b_en_i | input | 1 | Two-wire bus B enable |
| twi_b_scl_low_i | input | 1 | Bus B clock pull-low request |
| twi_b_sda_low_i | input | 1 | Bus B data pull-low request |
| twi_b_scl_o | output | 1 | Bus B clock line level |
| twi_b_sda_o | output | 1 | Bus B data line level |
| uart_en_i | input | 1 | UART enable |
| uart_tx_i | input | 1 | UART transmit |
| uart_rx_o | output | 1 | UART receive |
| cs_en_i | input | 4 | Chip-select enables |
| cs_i | input | 4 | Chip-select levels |
| pad_i | input | 8 | Pad input levels |
| pad_o | output | 8 | Pad output values |
| pad_oe_o | output | 8 | Pad output enables |

## Verification
A wrong ownership decision appears at pad_o/pad_oe_o in the same cycle the enables change. It also shows as a receive output stuck at 1, or a receive output passing a level it should block. A corrupted register shows on the GPIO pads one cycle after the write, and in rdata_o one cycle after a read. A synchronizer with the wrong depth shifts receive and readback timing by one edge. The bench checks that timing edge by edge.

// File: rtl/gpio_prio_pkg.sv
package gpio_prio_pkg;
  localparam int N_PINS = 8;
  localparam int N_ALT  = 3;
  localparam int N_CS   = 4;
  localparam int SYNC_STAGES = 2;

  typedef enum logic {
    REG_VAL = 1'b0,
    REG_DIR = 1'b1
  } reg_sel_e;
endpackage

// File: rtl/gpio_pad_sync.sv
module gpio_pad_sync #(
  parameter int WIDTH  = 8,
  parameter int STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < STAGES; s++) stage_q[s] <= '0;
    end else begin
      stage_q[0] <= d_i;
      for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
    end
  end

  assign q_o = stage_q[STAGES-1];

  // cycles since reset, saturating; used to bound the latency check
  logic [1:0] age_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            age_q <= '0;
    else if (age_q != 2'd3) age_q <= age_q + 2'd1;
  end

  assert_sync_lat_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (age_q >= 2'd2) |-> (q_o == $past(d_i, 2)));
endmodule

// File: rtl/gpio_port_regs.sv
module gpio_port_regs
  import gpio_prio_pkg::*;
#(
  parameter int WIDTH = N_PINS
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic             rd_en_i,
  input  logic             addr_i,
  input  logic [WIDTH-1:0] wdata_i,
  input  logic [WIDTH-1:0] pad_sync_i,
  output logic [WIDTH-1:0] val_q_o,
  output logic [WIDTH-1:0] dir_q_o,
  output logic [WIDTH-1:0] rdata_o
);
  reg_sel_e         sel;
  logic [WIDTH-1:0] val_q, dir_q, rdata_q, rd_mux;

  assign sel = reg_sel_e'(addr_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      val_q <= '0;
      dir_q <= '0;
    end else if (wr_en_i) begin
      if (sel == REG_VAL) val_q <= wdata_i;
      else                dir_q <= wdata_i;
    end
  end

  always_comb begin
    if (sel == REG_DIR) rd_mux = dir_q;
    else                rd_mux = (val_q & dir_q) | (pad_sync_i & ~dir_q);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      rdata_q <= '0;
    else if (rd_en_i) rdata_q <= rd_mux;
  end

  assign val_q_o = val_q;
  assign dir_q_o = dir_q;
  assign rdata_o = rdata_q;

  assert_wr_val_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !addr_i) |=> (val_q == $past(wdata_i)));

  assert_rd_dir_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && addr_i) |=> (rdata_o == $past(dir_q)));

  assert_rd_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_en_i |=> $stable(rdata_o));
endmodule

// File: rtl/gpio_pin_cell.sv
module gpio_pin_cell #(
  parameter int N_ALT = 3
) (
  input  logic [N_ALT-1:0] alt_en_i,
  input  logic [N_ALT-1:0] alt_out_i,
  input  logic [N_ALT-1:0] alt_oe_i,
  input  logic             gpio_out_i,
  input  logic             gpio_oe_i,
  output logic             pad_o,
  output logic             pad_oe_o,
  output logic [N_ALT-1:0] alt_sel_o
);
  logic claimed;

  // index 0 is the highest priority
  always_comb begin
    alt_sel_o = '0;
    claimed   = 1'b0;
    for (int k = 0; k < N_ALT; k++) begin
      if (!claimed && alt_en_i[k]) begin
        alt_sel_o[k] = 1'b1;
        claimed      = 1'b1;
      end
    end
  end

  assign pad_o    = claimed ? |(alt_sel_o & alt_out_i) : gpio_out_i;
  assign pad_oe_o = claimed ? |(alt_sel_o & alt_oe_i)  : gpio_oe_i;
endmodule

// File: rtl/gpio_prio_port.sv
module gpio_prio_port
  import gpio_prio_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic              addr_i,
  input  logic [N_PINS-1:0] wdata_i,
  output logic [N_PINS-1:0] rdata_o,
  input  logic              can_a_en_i,
  input  logic              can_a_tx_i,
  output logic              can_a_rx_o,
  input  logic              twi_a_en_i,
  input  logic              twi_a_scl_low_i,
  input  logic              twi_a_sda_low_i,
  output logic              twi_a_scl_o,
  output logic              twi_a_sda_o,
  input  logic              can_b_en_i,
  input  logic              can_b_tx_i,
  output logic              can_b_rx_o,
  input  logic              twi_b_en_i,
  input  logic              twi_b_scl_low_i,
  input  logic              twi_b_sda_low_i,
  output logic              twi_b_scl_o,
  output logic              twi_b_sda_o,
  input  logic              uart_en_i,
  input  logic              uart_tx_i,
  output logic              uart_rx_o,
  input  logic [N_CS-1:0]   cs_en_i,
  input  logic [N_CS-1:0]   cs_i,
  input  logic [N_PINS-1:0] pad_i,
  output logic [N_PINS-1:0] pad_o,
  output logic [N_PINS-1:0] pad_oe_o
);
  logic [N_PINS-1:0] pad_sync, val_q, dir_q;
  logic [N_ALT-1:0]  alt_en  [N_PINS];
  logic [N_ALT-1:0]  alt_out [N_PINS];
  logic [N_ALT-1:0]  alt_oe  [N_PINS];
  logic [N_ALT-1:0]  alt_sel [N_PINS];

  gpio_pad_sync #(.WIDTH(N_PINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pad_i),
    .q_o   (pad_sync)
  );

  gpio_port_regs #(.WIDTH(N_PINS)) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .rd_en_i   (rd_en_i),
    .addr_i    (addr_i),
    .wdata_i   (wdata_i),
    .pad_sync_i(pad_sync),
    .val_q_o   (val_q),
    .dir_q_o   (dir_q),
    .rdata_o   (rdata_o)
  );

  // Per-pin alternate candidates, slot 0 highest priority.
  // Open-drain slots: value 0, enable = pull-low request.
  always_comb begin
    for (int p = 0; p < N_PINS; p++) begin
      alt_en[p]  = '0;
      alt_out[p] = '0;
      alt_oe[p]  = '0;
    end
    // pin 7: CAN A tx, bus A clock, CAN B tx
    alt_en[7]  = {can_b_en_i, twi_a_en_i, can_a_en_i};
    alt_out[7] = {can_b_tx_i, 1'b0, can_a_tx_i};
    alt_oe[7]  = {1'b1, twi_a_scl_low_i, 1'b1};
    // pin 6: CAN A rx, bus A data, CAN B rx
    alt_en[6]  = {can_b_en_i, twi_a_en_i, can_a_en_i};
    alt_oe[6]  = {1'b0, twi_a_sda_low_i, 1'b0};
    // pin 5: bus B clock, cs2
    alt_en[5]  = {1'b0, cs_en_i[2], twi_b_en_i};
    alt_out[5] = {1'b0, cs_i[2], 1'b0};
    alt_oe[5]  = {1'b0, 1'b1, twi_b_scl_low_i};
    // pin 4: bus B data, cs0
    alt_en[4]  = {1'b0, cs_en_i[0], twi_b_en_i};
    alt_out[4] = {1'b0, cs_i[0], 1'b0};
    alt_oe[4]  = {1'b0, 1'b1, twi_b_sda_low_i};
    // pin 2: cs1
    alt_en[2]  = {2'b00, cs_en_i[1]};
    alt_out[2] = {2'b00, cs_i[1]};
    alt_oe[2]  = {2'b00, 1'b1};
    // pin 1: UART tx
    alt_en[1]  = {2'b00, uart_en_i};
    alt_out[1] = {2'b00, uart_tx_i};
    alt_oe[1]  = {2'b00, 1'b1};
    // pin 0: UART rx, cs3
    alt_en[0]  = {1'b0, cs_en_i[3], uart_en_i};
    alt_out[0] = {1'b0, cs_i[3], 1'b0};
    alt_oe[0]  = {1'b0, 1'b1, 1'b0};
  end

  for (genvar i = 0; i < N_PINS; i++) begin : g_pin
    gpio_pin_cell #(.N_ALT(N_ALT)) u_cell (
      .alt_en_i  (alt_en[i]),
      .alt_out_i (alt_out[i]),
      .alt_oe_i  (alt_oe[i]),
      .gpio_out_i(val_q[i]),
      .gpio_oe_i (dir_q[i]),
      .pad_o     (pad_o[i]),
      .pad_oe_o  (pad_oe_o[i]),
      .alt_sel_o (alt_sel[i])
    );
  end

  // receive paths: synchronized level to the owner, idle 1 otherwise
  assign can_a_rx_o  = alt_sel[6][0] ? pad_sync[6] : 1'b1;
  assign twi_a_scl_o = alt_sel[7][1] ? pad_sync[7] : 1'b1;
  assign twi_a_sda_o = alt_sel[6][1] ? pad_sync[6] : 1'b1;
  assign can_b_rx_o  = alt_sel[6][2] ? pad_sync[6] : 1'b1;
  assign twi_b_scl_o = alt_sel[5][0] ? pad_sync[5] : 1'b1;
  assign twi_b_sda_o = alt_sel[4][0] ? pad_sync[4] : 1'b1;
  assign uart_rx_o   = alt_sel[0][0] ? pad_sync[0] : 1'b1;

  assert_can_a_rx_in_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    can_a_en_i |-> (!pad_oe_o[6] && (twi_a_scl_o && twi_a_sda_o && can_b_rx_o)));

  assert_twi_a_od_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (twi_a_en_i && !can_a_en_i) |-> (!pad_o[7] && !pad_o[6]));

  assert_twi_b_od_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    twi_b_en_i |-> (!pad_o[5] && !pad_o[4] && pad_oe_o[4] == twi_b_sda_low_i));

  assert_pin3_dir_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i) |=> (pad_oe_o[3] == $past(wdata_i[3])));

  assert_uart_rx_in_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    uart_en_i |-> (!pad_oe_o[0] && pad_oe_o[1] && pad_o[1] == uart_tx_i));
endmodule

// File: tb/tb_gpio_prio_port.sv
`timescale 1ns/1ps
module tb_gpio_prio_port;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0, rd_en = 1'b0, addr = 1'b0;
  logic [7:0] wdata = '0, rdata;
  logic       can_a_en = 0, can_a_tx = 0, can_a_rx;
  logic       twi_a_en = 0, twi_a_scl_low = 0, twi_a_sda_low = 0, twi_a_scl, twi_a_sda;
  logic       can_b_en = 0, can_b_tx = 0, can_b_rx;
  logic       twi_b_en = 0, twi_b_scl_low = 0, twi_b_sda_low = 0, twi_b_scl, twi_b_sda;
  logic       uart_en = 0, uart_tx = 0, uart_rx;
  logic [3:0] cs_en = '0, cs = '0;
  logic [7:0] pad_in = '0, pad_out, pad_oe;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  gpio_prio_port dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .rd_en_i(rd_en), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata),
    .can_a_en_i(can_a_en), .can_a_tx_i(can_a_tx), .can_a_rx_o(can_a_rx),
    .twi_a_en_i(twi_a_en), .twi_a_scl_low_i(twi_a_scl_low), .twi_a_sda_low_i(twi_a_sda_low),
    .twi_a_scl_o(twi_a_scl), .twi_a_sda_o(twi_a_sda),
    .can_b_en_i(can_b_en), .can_b_tx_i(can_b_tx), .can_b_rx_o(can_b_rx),
    .twi_b_en_i(twi_b_en), .twi_b_scl_low_i(twi_b_scl_low), .twi_b_sda_low_i(twi_b_sda_low),
    .twi_b_scl_o(twi_b_scl), .twi_b_sda_o(twi_b_sda),
    .uart_en_i(uart_en), .uart_tx_i(uart_tx), .uart_rx_o(uart_rx),
    .cs_en_i(cs_en), .cs_i(cs), .pad_i(pad_in), .pad_o(pad_out), .pad_oe_o(pad_oe)
  );

  // en: {cs3,cs2,cs1,cs0,uart,twi_b,can_b,twi_a,can_a}
  // pv: {cs3..cs0, uart_tx, twi_b_sda_low, twi_b_scl_low, can_b_tx, twi_a_sda_low, twi_a_scl_low, can_a_tx}
  // rx: {uart, twi_b_sda, twi_b_scl, can_b, twi_a_sda, twi_a_scl, can_a}
  typedef struct packed {
    logic [8:0]  en;
    logic [10:0] pv;
    logic [7:0]  val;
    logic [7:0]  dir;
    logic [7:0]  e_out;
    logic [7:0]  e_oe;
    logic [6:0]  e_rx;
  } vec_t;

  localparam int N_VEC = 12;
  localparam vec_t VECS [N_VEC] = '{
    '{9'h000, 11'h000, 8'hA5, 8'hFF, 8'hA5, 8'hFF, 7'h7F},  // R8 gpio
    '{9'h000, 11'h000, 8'h3C, 8'h0F, 8'h3C, 8'h0F, 7'h7F},  // R8 gpio
    '{9'h001, 11'h001, 8'h00, 8'h00, 8'h80, 8'h80, 7'h7E},  // R3 CAN A
    '{9'h003, 11'h006, 8'hFF, 8'hFF, 8'h3F, 8'hBF, 7'h7E},  // R3 CAN A over bus A
    '{9'h006, 11'h00A, 8'hFF, 8'h00, 8'h3F, 8'h80, 7'h79},  // R3 R5 bus A over CAN B
    '{9'h004, 11'h008, 8'h00, 8'hFF, 8'h80, 8'hBF, 7'h77},  // R3 R8 CAN B, dir ignored
    '{9'h0A8, 11'h2A0, 8'h00, 8'h00, 8'h00, 8'h10, 7'h4F},  // R4 R5 bus B over cs
    '{9'h0E0, 11'h280, 8'h00, 8'h00, 8'h30, 8'h34, 7'h7F},  // R4 R7 chip selects
    '{9'h110, 11'h440, 8'h00, 8'hFF, 8'h02, 8'hFE, 7'h3F},  // R7 UART over cs3
    '{9'h100, 11'h000, 8'hFF, 8'h00, 8'hFE, 8'h01, 7'h7F},  // R7 cs3
    '{9'h1FF, 11'h7FF, 8'h00, 8'h00, 8'h86, 8'hB6, 7'h0E},  // R3 R4 R7 all enabled
    '{9'h1FF, 11'h7FF, 8'h08, 8'h08, 8'h8E, 8'hBE, 7'h0E}   // R6 pin 3 stays gpio
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic a, input logic [7:0] v);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = v;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic bus_read(input logic a, output logic [7:0] v);
    @(negedge clk);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    v = rdata;
  endtask

  task automatic apply(input vec_t v);
    {cs_en, uart_en, twi_b_en, can_b_en, twi_a_en, can_a_en} = v.en;
    {cs, uart_tx, twi_b_sda_low, twi_b_scl_low, can_b_tx, twi_a_sda_low, twi_a_scl_low, can_a_tx} = v.pv;
  endtask

  function automatic logic [6:0] rx_bus();
    return {uart_rx, twi_b_sda, twi_b_scl, can_b_rx, twi_a_sda, twi_a_scl, can_a_rx};
  endfunction

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] rd;
    repeat (3) @(negedge clk);
    // R11 reset state
    check("R11 pad_oe", pad_oe, 8'h00);
    check("R11 rdata", rdata, 8'h00);
    check("R11 rx idle", rx_bus(), 7'h7F);
    rst_n = 1'b1;
    bus_read(1'b1, rd);
    check("R11 dir reset", rd, 8'h00);

    // vector table
    for (int i = 0; i < N_VEC; i++) begin
      @(negedge clk);
      apply(VECS[i]);
      pad_in = 8'h00;
      bus_write(1'b0, VECS[i].val);
      bus_write(1'b1, VECS[i].dir);
      repeat (3) @(negedge clk);
      check($sformatf("R3-8 vec%0d pad_o", i), pad_out, VECS[i].e_out);
      check($sformatf("R3-8 vec%0d pad_oe", i), pad_oe, VECS[i].e_oe);
      check($sformatf("R10 vec%0d rx", i), rx_bus(), VECS[i].e_rx);
    end

    // R10 owner passes high pad levels, non-owner stays 1
    @(negedge clk);
    apply('{9'h00A, 11'h000, 8'h00, 8'h00, 8'h00, 8'h00, 7'h00});
    pad_in = 8'h00;
    repeat (3) @(negedge clk);
    check("R10 twi_b low level", {twi_b_sda, twi_b_scl}, 2'b00);
    check("R10 twi_a low level", {twi_a_sda, twi_a_scl}, 2'b00);
    check("R10 can_b not owner", can_b_rx, 1'b1);
    pad_in = 8'hF0;
    repeat (3) @(negedge clk);
    check("R10 twi_b high level", {twi_b_sda, twi_b_scl}, 2'b11);
    check("R5 released lines", pad_oe & 8'hF0, 8'h00);

    // R9 synchronizer latency on the UART receive path
    @(negedge clk);
    apply('{9'h010, 11'h000, 8'h00, 8'h00, 8'h00, 8'h00, 7'h00});
    pad_in = 8'h00;
    repeat (3) @(negedge clk);
    pad_in = 8'h01;
    @(posedge clk); #1;
    check("R9 after one edge", uart_rx, 1'b0);
    @(posedge clk); #1;
    check("R9 after two edges", uart_rx, 1'b1);

    // R1 write visible on GPIO pads in the next cycle
    @(negedge clk);
    apply('{9'h000, 11'h000, 8'h00, 8'h00, 8'h00, 8'h00, 7'h00});
    bus_write(1'b1, 8'hFF);
    @(negedge clk);
    wr_en = 1'b1; addr = 1'b0; wdata = 8'h3C;
    @(posedge clk); #1;
    wr_en = 1'b0;
    check("R1 next-cycle pad", pad_out, 8'h3C);
    bus_read(1'b0, rd);
    check("R1 readback dir=1", rd, 8'h3C);

    // R2 mixed readback and hold
    bus_write(1'b0, 8'hA5);
    bus_write(1'b1, 8'h0F);
    pad_in = 8'h5A;
    repeat (3) @(negedge clk);
    bus_read(1'b0, rd);
    check("R2 mixed readback", rd, 8'h55);
    pad_in = 8'hFF;
    repeat (3) @(negedge clk);
    check("R2 held without read", rdata, 8'h55);
    bus_read(1'b1, rd);
    check("R2 dir readback", rd, 8'h0F);

    // R11 reset mid-run
    @(negedge clk);
    rst_n = 1'b0;
    pad_in = 8'h00;
    @(negedge clk);
    check("R11 pad_oe after reset", pad_oe, 8'h00);
    check("R11 rdata after reset", rdata, 8'h00);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    bus_read(1'b0, rd);
    check("R11 value after reset", rd, 8'h00);
    bus_read(1'b1, rd);
    check("R11 dir after reset", rd, 8'h00);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule